// File: doc/BRIEF.md
# Two-Way Cache Lookup and Write-Policy Controller

This block sits in front of the data array of a 4 KB data cache. The cache has two ways and 16-byte lines. Each cycle it receives at most one request from the processor side. The request carries an address, a read or write flag, the access size and three bus attributes: lookup (cacheable), bufferable and privileged. The block decides in that same cycle how the request is handled. It can be served from the cache, forwarded to memory unchanged, turned into a line refill (with an eviction of a dirty victim in front of it), or written through to memory.

The block holds the tag, valid, dirty and privilege state for every line, plus one replacement bit per set. It updates this state on the clock edge that ends the request. It produces no data itself. Its outputs steer the data array (way, write strobe, byte enables), the master-side sequencer (command, address, eviction descriptor) and external performance counters (one-cycle pulses).

Top module: `tag_policy_ctrl`

## Requirements
- R1: The address is split into byte offset [3:0], set index [10:4] (128 sets) and tag [31:11]. An eviction address is rebuilt as {stored tag, index, 4'b0000}.
- R2: A request with `req_lookup`=0 gives `m_cmd`=1 (pass) and `m_addr`=`req_addr` in the same cycle. It changes no cache state and raises no counter pulse.
- R3: While `en`=0, every request gives `m_cmd`=1 (pass) with no tag compare. Every clock edge with `en`=0 clears all valid, dirty and privilege bits, so lines cached before the disable miss afterwards.
- R4: A cacheable read that hits gives `cache_hit`=1 in the same cycle, with no master command (`m_cmd`=0) and a `rd_hit` pulse.
- R5: A cacheable read that misses gives `m_cmd`=2 (refill) with `m_addr`=`req_addr` and a `rd_miss` pulse. It allocates the line clean, with privilege equal to `req_priv`.
- R6: A write with lookup=1 and bufferable=1 that hits raises `cache_wr` with no master command, and it marks the line dirty.
- R7: A write with lookup=1 and bufferable=1 that misses issues a refill and raises `cache_wr` for the merge. It allocates the line dirty and raises a `wr_miss` pulse.
- R8: A write with lookup=1 and bufferable=0 that hits raises both `cache_wr` and `m_cmd`=3 (write-through). The dirty bit is left unchanged.
- R9: A write with lookup=1 and bufferable=0 that misses gives `m_cmd`=3 with `cache_wr`=0 and allocates nothing.
- R10: Each set has one replacement bit, which is 0 after reset. A miss that allocates fills the way that bit names. Every hit or fill sets the bit to the other way. `cache_way` reports the way hit or filled, and is 0 otherwise.
- R11: When the victim of a refill is valid and dirty, `ev_valid`=1, `ev_addr` is the victim line address and `ev_priv` is the victim's stored privilege bit. A clean or invalid victim gives `ev_valid`=0 and zeros on `ev_addr` and `ev_priv`.
- R12: `ev_attr` is 6'b111111 while `ev_valid`=1 and 0 otherwise. The bits, from bit 5 down to bit 0, are data, cacheable, write-back, allocate, normal memory and non-shareable. The write-back is a four-beat incrementing burst.
- R13: `cache_be` is nonzero only while `cache_wr`=1. For size 0 it is 4'b0001<<addr[1:0]. For size 1 it is 4'b0011 or 4'b1100, selected by addr[1]. For sizes 2 and 3 it is 4'b1111.
- R14: Each cacheable request raises exactly one of `rd_hit`, `rd_miss`, `wr_hit`, `wr_miss` for one cycle. Idle cycles and requests that are not cached raise none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Cache enable; low bypasses and clears state |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Request byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 half-word, 2 word |
| req_lookup | input | 1 | Cacheable attribute |
| req_buf | input | 1 | Bufferable attribute (write-back when 1) |
| req_priv | input | 1 | Privileged attribute |
| cache_hit | output | 1 | Request hits a valid line |
| cache_way | output | 1 | Way hit or filled |
| cache_wr | output | 1 | Write strobe to the data array |
| cache_be | output | 4 | Byte enables for the data array write |
| m_cmd | output | 2 | 0 none, 1 pass, 2 refill, 3 write-through |
| m_addr | output | 32 | Address carried with `m_cmd` |
| ev_valid | output | 1 | Dirty victim must be written back before refill |
| ev_addr | output | 32 | Victim line address |
| ev_priv | output | 1 | Privilege attribute of the write-back |
| ev_attr | output | 6 | Fixed attributes of the write-back |
| rd_hit | output | 1 | Read hit pulse |
| rd_miss | output | 1 | Read miss pulse |
| wr_hit | output | 1 | Write hit pulse |
| wr_miss | output | 1 | Write miss pulse |

## Verification
Every decision output is combinational from the request and the stored state, so each result is due in the cycle the request is presented. State updates take effect at the next rising edge and are seen by the request that follows. The bench drives a request at the falling edge, compares all outputs 1 ns later against a bench model, and then advances the model as the edge will. A later request therefore observes allocations, dirty marking, replacement bits and the clear caused by disabling. The eviction address and privilege expose the stored tag and privilege state.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
  localparam int WAYS = 2;

  typedef enum logic [1:0] {
    MC_NONE   = 2'd0,
    MC_PASS   = 2'd1,
    MC_REFILL = 2'd2,
    MC_WTHRU  = 2'd3
  } mcmd_e;

  // data, cacheable, write-back, allocate, normal, non-shareable
  localparam logic [5:0] EVICT_ATTR = 6'b111111;
endpackage

// File: rtl/tpc_tag_store.sv
module tpc_tag_store #(
  parameter int IDX_W = 7,
  parameter int TAG_W = 21
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clr_all,
  input  logic [IDX_W-1:0]      idx,
  output logic [1:0][TAG_W-1:0] rd_tag,
  output logic [1:0]            rd_val,
  output logic [1:0]            rd_dirty,
  output logic [1:0]            rd_priv,
  input  logic                  wr_en,
  input  logic                  wr_way,
  input  logic [TAG_W-1:0]      wr_tag,
  input  logic                  wr_dirty,
  input  logic                  wr_priv
);
  localparam int SETS = 1 << IDX_W;

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [TAG_W-1:0] tag_mem [SETS];
    logic [SETS-1:0]  val_q, dirty_q, priv_q;
    logic             we;

    assign we = wr_en && (wr_way == 1'(w));

    // tag array: no reset, so it can map to distributed RAM
    always_ff @(posedge clk) begin
      if (we) tag_mem[idx] <= wr_tag;
    end

    always_ff @(posedge clk) begin
      if (rst || clr_all) begin
        val_q   <= '0;
        dirty_q <= '0;
        priv_q  <= '0;
      end else if (we) begin
        val_q[idx]   <= 1'b1;
        dirty_q[idx] <= wr_dirty;
        priv_q[idx]  <= wr_priv;
      end
    end

    assign rd_tag[w]   = tag_mem[idx];
    assign rd_val[w]   = val_q[idx];
    assign rd_dirty[w] = dirty_q[idx];
    assign rd_priv[w]  = priv_q[idx];
  end
endmodule

// File: rtl/tpc_plru.sv
module tpc_plru #(
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] idx,
  input  logic             upd,
  input  logic             used_way,
  output logic             victim
);
  localparam int SETS = 1 << IDX_W;

  logic [SETS-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (rst)      ptr_q <= '0;
    else if (upd) ptr_q[idx] <= ~used_way;
  end

  assign victim = ptr_q[idx];
endmodule

// File: rtl/tpc_decide.sv
module tpc_decide
  import tpc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 4,
  parameter int IDX_W  = 7,
  parameter int TAG_W  = 21
) (
  input  logic                  en,
  input  logic                  req_valid,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic                  req_write,
  input  logic [1:0]            req_size,
  input  logic                  req_lookup,
  input  logic                  req_buf,
  input  logic                  req_priv,
  input  logic [1:0][TAG_W-1:0] way_tag,
  input  logic [1:0]            way_val,
  input  logic [1:0]            way_dirty,
  input  logic [1:0]            way_priv,
  input  logic                  victim,
  output logic                  cache_hit,
  output logic                  cache_way,
  output logic                  cache_wr,
  output logic [3:0]            cache_be,
  output mcmd_e                 m_cmd,
  output logic [ADDR_W-1:0]     m_addr,
  output logic                  ev_valid,
  output logic [ADDR_W-1:0]     ev_addr,
  output logic                  ev_priv,
  output logic                  rd_hit,
  output logic                  rd_miss,
  output logic                  wr_hit,
  output logic                  wr_miss,
  output logic                  te_we,
  output logic                  te_dirty,
  output logic                  te_priv,
  output logic                  lru_upd
);
  logic [TAG_W-1:0] req_tag;
  logic [IDX_W-1:0] req_idx;
  logic [1:0]       hit_w;
  logic             hit_way, thru;
  logic [3:0]       be_raw;

  assign req_tag = req_addr[ADDR_W-1 -: TAG_W];
  assign req_idx = req_addr[OFF_W +: IDX_W];
  assign hit_way = hit_w[1];
  assign thru    = req_write && !req_buf;

  for (genvar w = 0; w < 2; w++) begin : g_cmp
    assign hit_w[w] = way_val[w] && (way_tag[w] == req_tag);
  end

  always_comb begin
    unique case (req_size)
      2'd0:    be_raw = 4'b0001 << req_addr[1:0];
      2'd1:    be_raw = req_addr[1] ? 4'b1100 : 4'b0011;
      default: be_raw = 4'b1111;
    endcase
  end

  always_comb begin
    cache_hit = 1'b0; cache_way = 1'b0; cache_wr = 1'b0;
    m_cmd = MC_NONE;  m_addr = '0;
    ev_valid = 1'b0;  ev_addr = '0;     ev_priv = 1'b0;
    rd_hit = 1'b0; rd_miss = 1'b0; wr_hit = 1'b0; wr_miss = 1'b0;
    te_we = 1'b0; te_dirty = 1'b0; te_priv = 1'b0; lru_upd = 1'b0;
    if (req_valid && !(en && req_lookup)) begin
      m_cmd  = MC_PASS;
      m_addr = req_addr;
    end else if (req_valid) begin
      if (|hit_w) begin
        cache_hit = 1'b1;
        cache_way = hit_way;
        lru_upd   = 1'b1;
        if (!req_write) begin
          rd_hit = 1'b1;
        end else begin
          wr_hit   = 1'b1;
          cache_wr = 1'b1;
          if (thru) begin
            m_cmd  = MC_WTHRU;
            m_addr = req_addr;
          end else begin
            te_we    = 1'b1;
            te_dirty = 1'b1;
            te_priv  = way_priv[hit_way];
          end
        end
      end else if (thru) begin
        wr_miss = 1'b1;
        m_cmd   = MC_WTHRU;
        m_addr  = req_addr;
      end else begin
        rd_miss   = !req_write;
        wr_miss   = req_write;
        m_cmd     = MC_REFILL;
        m_addr    = req_addr;
        cache_way = victim;
        cache_wr  = req_write;
        lru_upd   = 1'b1;
        te_we     = 1'b1;
        te_dirty  = req_write;
        te_priv   = req_priv;
        if (way_val[victim] && way_dirty[victim]) begin
          ev_valid = 1'b1;
          ev_addr  = {way_tag[victim], req_idx, OFF_W'(0)};
          ev_priv  = way_priv[victim];
        end
      end
    end
    cache_be = cache_wr ? be_raw : 4'b0000;
  end
endmodule

// File: rtl/tag_policy_ctrl.sv
module tag_policy_ctrl
  import tpc_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CACHE_BYTES = 4096,
  parameter int LINE_BYTES  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic              req_lookup,
  input  logic              req_buf,
  input  logic              req_priv,
  output logic              cache_hit,
  output logic              cache_way,
  output logic              cache_wr,
  output logic [3:0]        cache_be,
  output logic [1:0]        m_cmd,
  output logic [ADDR_W-1:0] m_addr,
  output logic              ev_valid,
  output logic [ADDR_W-1:0] ev_addr,
  output logic              ev_priv,
  output logic [5:0]        ev_attr,
  output logic              rd_hit,
  output logic              rd_miss,
  output logic              wr_hit,
  output logic              wr_miss
);
  localparam int SETS  = CACHE_BYTES / (WAYS * LINE_BYTES);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  logic [IDX_W-1:0]      idx;
  logic [1:0][TAG_W-1:0] way_tag;
  logic [1:0]            way_val, way_dirty, way_priv;
  logic                  victim, te_we, te_dirty, te_priv, lru_upd;
  mcmd_e                 cmd;

  assign idx     = req_addr[OFF_W +: IDX_W];
  assign m_cmd   = cmd;
  assign ev_attr = ev_valid ? EVICT_ATTR : 6'd0;

  tpc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst(rst), .clr_all(!en), .idx(idx),
    .rd_tag(way_tag), .rd_val(way_val), .rd_dirty(way_dirty), .rd_priv(way_priv),
    .wr_en(te_we), .wr_way(cache_way), .wr_tag(req_addr[ADDR_W-1 -: TAG_W]),
    .wr_dirty(te_dirty), .wr_priv(te_priv)
  );

  tpc_plru #(.IDX_W(IDX_W)) u_plru (
    .clk(clk), .rst(rst), .idx(idx), .upd(lru_upd),
    .used_way(cache_way), .victim(victim)
  );

  tpc_decide #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_dec (
    .en(en), .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
    .req_size(req_size), .req_lookup(req_lookup), .req_buf(req_buf), .req_priv(req_priv),
    .way_tag(way_tag), .way_val(way_val), .way_dirty(way_dirty), .way_priv(way_priv),
    .victim(victim), .cache_hit(cache_hit), .cache_way(cache_way), .cache_wr(cache_wr),
    .cache_be(cache_be), .m_cmd(cmd), .m_addr(m_addr), .ev_valid(ev_valid),
    .ev_addr(ev_addr), .ev_priv(ev_priv), .rd_hit(rd_hit), .rd_miss(rd_miss),
    .wr_hit(wr_hit), .wr_miss(wr_miss), .te_we(te_we), .te_dirty(te_dirty),
    .te_priv(te_priv), .lru_upd(lru_upd)
  );
endmodule

// File: rtl/tpc_checker.sv
module tpc_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_write,
  input logic              req_lookup,
  input logic              req_buf,
  input logic              cache_hit,
  input logic              cache_wr,
  input logic [1:0]        m_cmd,
  input logic              ev_valid,
  input logic              rd_hit,
  input logic              rd_miss,
  input logic              wr_hit,
  input logic              wr_miss
);
  // R14
  pulse_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rd_hit, rd_miss, wr_hit, wr_miss}));

  // R2
  bypass_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_lookup) |->
      (m_cmd == 2'd1 && !cache_wr && {rd_hit, rd_miss, wr_hit, wr_miss} == 4'd0));

  // R3
  disabled_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !en) |-> (m_cmd == 2'd1 && !cache_hit));

  // R4
  rd_hit_no_master_chk: assert property (@(posedge clk) disable iff (rst)
    rd_hit |-> (m_cmd == 2'd0 && cache_hit));

  // R9
  wthru_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && en && req_lookup && req_write && !req_buf) |-> (m_cmd == 2'd3));

  // R11
  evict_with_refill_chk: assert property (@(posedge clk) disable iff (rst)
    ev_valid |-> (m_cmd == 2'd2));

  // R5
  refill_then_hit_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(rd_miss) && req_valid && en && req_lookup && !req_write &&
     req_addr == $past(req_addr)) |-> cache_hit);
endmodule

bind tag_policy_ctrl tpc_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_tag_policy_ctrl.sv
module tb_tag_policy_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst, en, req_valid, req_write, req_lookup, req_buf, req_priv;
  logic [31:0] req_addr;
  logic [1:0]  req_size;
  logic        cache_hit, cache_way, cache_wr, ev_valid, ev_priv;
  logic        rd_hit, rd_miss, wr_hit, wr_miss;
  logic [3:0]  cache_be;
  logic [1:0]  m_cmd;
  logic [31:0] m_addr, ev_addr;
  logic [5:0]  ev_attr;

  always #(CLK_PERIOD/2) clk = ~clk;

  tag_policy_ctrl dut (.*);

  // bench model of the cache state
  bit [20:0] mtag [2][128];
  bit        mval [2][128];
  bit        mdirty [2][128];
  bit        mpriv [2][128];
  bit        mlru [128];

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input string rq, input string fld, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", rq, fld, act, exp);
    end
  endtask

  task automatic model_clear(input bit with_lru);
    for (int w = 0; w < 2; w++)
      for (int i = 0; i < 128; i++) begin
        mval[w][i] = 0; mdirty[w][i] = 0; mpriv[w][i] = 0;
        if (with_lru) mlru[i] = 0;
      end
  endtask

  function automatic logic [3:0] exp_be(input logic [1:0] sz, input logic [1:0] lo);
    case (sz)
      2'd0:    return 4'b0001 << lo;
      2'd1:    return lo[1] ? 4'b1100 : 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  // drive one request at the falling edge, check 1 ns later, advance model
  task automatic apply(input bit v, input logic [31:0] a, input bit wr, input logic [1:0] sz,
                       input bit lk, input bit bf, input bit pv, input bit e);
    logic [1:0] e_cmd; logic [31:0] e_maddr, e_evaddr; logic [3:0] e_be, e_pulse;
    bit e_hit, e_way, e_wr, e_ev, e_evpriv, h0, h1, hw, vw;
    logic [20:0] t; logic [6:0] ix; string rq;
    @(negedge clk);
    req_valid = v; req_addr = a; req_write = wr; req_size = sz;
    req_lookup = lk; req_buf = bf; req_priv = pv; en = e;
    #1;
    t = a[31:11]; ix = a[10:4];
    e_cmd = 0; e_maddr = 0; e_evaddr = 0; e_be = 0; e_pulse = 0;
    e_hit = 0; e_way = 0; e_wr = 0; e_ev = 0; e_evpriv = 0; rq = "R14";
    if (v && !(e && lk)) begin
      e_cmd = 1; e_maddr = a; rq = e ? "R2" : "R3";
    end else if (v) begin
      h0 = mval[0][ix] && mtag[0][ix] == t;
      h1 = mval[1][ix] && mtag[1][ix] == t;
      if (h0 || h1) begin
        hw = h1; e_hit = 1; e_way = hw; mlru[ix] = !hw;
        if (!wr) begin e_pulse = 4'b1000; rq = "R4"; end
        else begin
          e_pulse = 4'b0010; e_wr = 1; e_be = exp_be(sz, a[1:0]);
          if (!bf) begin e_cmd = 3; e_maddr = a; rq = "R8"; end
          else begin mdirty[hw][ix] = 1; rq = "R6"; end
        end
      end else if (wr && !bf) begin
        e_pulse = 4'b0001; e_cmd = 3; e_maddr = a; rq = "R9";
      end else begin
        vw = mlru[ix]; e_way = vw; e_cmd = 2; e_maddr = a;
        e_pulse = wr ? 4'b0001 : 4'b0100; rq = wr ? "R7" : "R5";
        e_wr = wr; if (wr) e_be = exp_be(sz, a[1:0]);
        if (mval[vw][ix] && mdirty[vw][ix]) begin
          e_ev = 1; e_evaddr = {mtag[vw][ix], ix, 4'b0000}; e_evpriv = mpriv[vw][ix];
        end
        mtag[vw][ix] = t; mval[vw][ix] = 1; mdirty[vw][ix] = wr;
        mpriv[vw][ix] = pv; mlru[ix] = !vw;
      end
    end
    chk(rq, "m_cmd", 32'(m_cmd), 32'(e_cmd));
    chk(rq, "m_addr", m_addr, e_maddr);
    chk(rq, "cache_hit", 32'(cache_hit), 32'(e_hit));
    chk(rq, "cache_wr", 32'(cache_wr), 32'(e_wr));
    chk("R10", "cache_way", 32'(cache_way), 32'(e_way));
    chk("R13", "cache_be", 32'(cache_be), 32'(e_be));
    chk("R14", "pulses", 32'({rd_hit, rd_miss, wr_hit, wr_miss}), 32'(e_pulse));
    chk("R11", "ev_valid", 32'(ev_valid), 32'(e_ev));
    chk("R11", "ev_priv", 32'(ev_priv), 32'(e_evpriv));
    chk("R1", "ev_addr", ev_addr, e_evaddr);
    chk("R12", "ev_attr", 32'(ev_attr), e_ev ? 32'h3f : 32'h0);
    if (!e) model_clear(0);
  endtask

  function automatic logic [31:0] mk(input logic [20:0] t, input logic [6:0] ix, input logic [3:0] off);
    return {t, ix, off};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    logic [20:0] tags [4];
    seed = 32'h1c3a;
    void'($urandom(seed));
    tags[0] = 21'h0a5a5; tags[1] = 21'h13c01; tags[2] = 21'h00001; tags[3] = 21'h1ffff;
    rst = 1; en = 0; req_valid = 0; req_addr = 0; req_write = 0; req_size = 0;
    req_lookup = 0; req_buf = 0; req_priv = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    model_clear(1);
    // reset state: idle, nothing pulsed (R14)
    apply(0, 0, 0, 0, 0, 0, 0, 1);
    // R5 read miss then R4 hit, set 5
    apply(1, mk(tags[0], 5, 4'h4), 0, 2, 1, 1, 1, 1);
    apply(1, mk(tags[0], 5, 4'h8), 0, 2, 1, 1, 0, 1);
    // R7 write-back miss fills the other way (R10), half-word
    apply(1, mk(tags[1], 5, 4'h6), 1, 1, 1, 1, 1, 1);
    // R10 third tag replaces way 0 (clean, no eviction)
    apply(1, mk(tags[2], 5, 4'h0), 0, 2, 1, 1, 0, 1);
    // R11 refetch of tags[0] evicts the dirty tags[1] line with its privilege
    apply(1, mk(tags[0], 5, 4'hc), 0, 2, 1, 1, 0, 1);
    // R9 write-through miss, then read still misses
    apply(1, mk(tags[3], 9, 4'h1), 1, 0, 1, 0, 0, 1);
    apply(1, mk(tags[3], 9, 4'h1), 0, 0, 1, 0, 0, 1);
    // R8 write-through hit, byte lane 3 (R13)
    apply(1, mk(tags[3], 9, 4'h3), 1, 0, 1, 0, 0, 1);
    // R6 write-back hit then R2 non-cacheable request
    apply(1, mk(tags[3], 9, 4'h0), 1, 2, 1, 1, 0, 1);
    apply(1, mk(tags[3], 9, 4'h0), 0, 2, 0, 1, 0, 1);
    // R3 disable clears, then the line misses
    apply(1, mk(tags[3], 9, 4'h0), 0, 2, 1, 1, 0, 0);
    apply(1, mk(tags[3], 9, 4'h0), 0, 2, 1, 1, 0, 1);
    // constrained random mix
    for (int n = 0; n < 1500; n++) begin
      int unsigned r;
      r = $urandom;
      apply(r[0] | r[1], mk(tags[r[3:2]], 7'(r[5:4]) + 7'd40, 4'(r[9:6])),
            r[10], 2'(r[12:11]), (r[15:13] != 0), r[16], r[17], (r[23:18] != 0));
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule